// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single output compare channel placed next to a free-running timer. The timer itself lives outside the block. Each clock the channel sees the timer count and a one-cycle strobe that marks the end of the timer period. It compares the count against a primary and a secondary compare value and drives one output pin according to a 3-bit mode field. It also raises a one-cycle interrupt pulse on the pin edge that belongs to the active mode.

The modes cover a rising or falling one-shot, toggling on a match, a delayed single pulse, a pulse that repeats every period, and pulse-width modulation. PWM comes in a plain form and in a form with fault shutdown. In that second form an active-low fault input forces the pin low at once and sets a sticky fault flag. The flag is cleared, and the output released, only by writing a new mode. While the mode field is 000 the pin simply copies a general-purpose fallback value.

Every write of a different mode value puts the pin in that mode's starting level on the next clock. It also rearms the delayed single pulse. In PWM the primary value sets the duty of the first period. From then on the secondary value is loaded into a duty latch at each period strobe.

Top module: `ocmp_channel`

## Requirements
- R1: While reset is asserted, pin_o, irq_o and flt_o are all 0.
- R2: With mode 000 held, pin_o takes the value gpio_val had one clock earlier, and irq_o stays 0.
- R3: On the clock after mode takes a value different from the one in use, pin_o becomes the new mode's starting level: 0 for 001, 100 and 101; 1 for 010; unchanged for 011; gpio_val for 000; and, for 110 and 111, 1 if cmp_a is non-zero, else 0. irq_o is 0 on that clock.
- R4: Mode 001: on the clock after tmr_cnt equals cmp_a the pin goes to 1, and irq_o pulses for one cycle on that rising edge.
- R5: Mode 010: on the clock after tmr_cnt equals cmp_a the pin goes to 0, and irq_o pulses on that falling edge.
- R6: Mode 011: each match of tmr_cnt with cmp_a inverts the pin on the next clock, and irq_o pulses on both rising and falling edges.
- R7: Mode 100: the pin rises after a match with cmp_a and falls after a match with cmp_b. irq_o pulses only on the fall. After the fall the pin stays low until a mode change rearms it.
- R8: Mode 101: like mode 100, but the rise and fall repeat every time the matches recur.
- R9: Modes 110 and 111: on a tmr_pm strobe the pin goes to 1 if cmp_b is non-zero (otherwise 0) and cmp_b is latched as duty. The pin goes to 0 after tmr_cnt equals the latched duty. A change of cmp_b within a period has no effect before the next strobe. Mode 110 never pulses irq_o and ignores flt_n.
- R10: Mode 111: while flt_n is 0, pin_o is 0 in the same cycle. On the clock after flt_n falls, flt_o becomes 1 and irq_o pulses once. The pin then stays 0, even across period strobes, until a new mode value is written, which clears flt_o.
- R11: pin_o and irq_o change on the clock edge that follows the cycle in which the compare condition is seen, so irq_o is high in the same cycle that shows the new pin level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_cnt | input | TW | Current timer count |
| tmr_pm | input | 1 | One-cycle strobe at the timer period boundary |
| cmp_a | input | TW | Primary compare value (rise point, first PWM duty) |
| cmp_b | input | TW | Secondary compare value (fall point, PWM duty) |
| mode | input | 3 | Operating mode code |
| gpio_val | input | 1 | Pin level used while mode is 000 |
| flt_n | input | 1 | Active-low fault input, used in mode 111 |
| pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | One-cycle compare interrupt pulse |
| flt_o | output | 1 | Sticky fault status flag |

## Verification
In mode 111 the fault input can drop in the very cycle that the period strobe asks the pin to rise for a new PWM period. The bench lines up a falling flt_n with tmr_pm high while the duty is non-zero. It expects the shutdown to win: the pin stays low, flt_o sets and irq_o pulses exactly once. The same clash is also checked after a mode rewrite, which must release the pin so that the next PWM period runs normally.

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tmr_cnt,
  input  logic          tmr_pm,
  input  logic [TW-1:0] cmp_a,
  input  logic [TW-1:0] cmp_b,
  input  logic [2:0]    mode,
  input  logic          gpio_val,
  input  logic          flt_n,
  output logic          pin_o,
  output logic          irq_o,
  output logic          flt_o
);
  localparam logic [2:0] M_OFF  = 3'b000;
  localparam logic [2:0] M_HI   = 3'b001;
  localparam logic [2:0] M_LO   = 3'b010;
  localparam logic [2:0] M_TGL  = 3'b011;
  localparam logic [2:0] M_DLY  = 3'b100;
  localparam logic [2:0] M_CONT = 3'b101;
  localparam logic [2:0] M_PWMF = 3'b111;

  logic [2:0]    mode_q;
  logic [TW-1:0] duty_q;
  logic          pin_q, done_q, flt_q, flt_d, irq_q;
  logic          pin_n, done_n, irq_n, pin_init;

  wire chg      = mode != mode_q;
  wire hit_a    = tmr_cnt == cmp_a;
  wire hit_b    = tmr_cnt == cmp_b;
  wire hit_d    = tmr_cnt == duty_q;
  wire pwm_m    = mode_q[2:1] == 2'b11;
  wire guard    = (mode_q == M_PWMF) & (~flt_n | flt_q);
  wire flt_fall = flt_d & ~flt_n;

  always_comb begin
    case (mode)
      M_OFF:               pin_init = gpio_val;
      M_HI, M_DLY, M_CONT: pin_init = 1'b0;
      M_LO:                pin_init = 1'b1;
      M_TGL:               pin_init = pin_q;
      default:             pin_init = |cmp_a;
    endcase
  end

  always_comb begin
    pin_n  = pin_q;
    done_n = done_q;
    case (mode_q)
      M_OFF: pin_n = gpio_val;
      M_HI:  if (hit_a) pin_n = 1'b1;
      M_LO:  if (hit_a) pin_n = 1'b0;
      M_TGL: if (hit_a) pin_n = ~pin_q;
      M_DLY, M_CONT: begin
        if (hit_b && pin_q) begin
          pin_n = 1'b0;
          if (mode_q == M_DLY) done_n = 1'b1;
        end else if (hit_a && !pin_q && !done_q) begin
          pin_n = 1'b1;
        end
      end
      default: begin
        if (guard)       pin_n = 1'b0;
        else if (tmr_pm) pin_n = |cmp_b;
        else if (hit_d)  pin_n = 1'b0;
      end
    endcase
  end

  always_comb begin
    case (mode_q)
      M_HI:                irq_n = ~pin_q & pin_n;
      M_LO, M_DLY, M_CONT: irq_n = pin_q & ~pin_n;
      M_TGL:               irq_n = pin_q ^ pin_n;
      M_PWMF:              irq_n = flt_fall;
      default:             irq_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_OFF;
      duty_q <= '0;
      pin_q  <= 1'b0;
      done_q <= 1'b0;
      flt_q  <= 1'b0;
      flt_d  <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      flt_d <= flt_n;
      if (chg) begin
        mode_q <= mode;
        pin_q  <= pin_init;
        duty_q <= cmp_a;
        done_q <= 1'b0;
        flt_q  <= 1'b0;
        irq_q  <= 1'b0;
      end else begin
        pin_q  <= pin_n;
        done_q <= done_n;
        irq_q  <= irq_n;
        if (pwm_m && tmr_pm) duty_q <= cmp_b;
        if (mode_q == M_PWMF && !flt_n) flt_q <= 1'b1;
      end
    end
  end

  assign pin_o = pin_q & ~((mode_q == M_PWMF) & ~flt_n);
  assign irq_o = irq_q;
  assign flt_o = flt_q;
endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] tmr_cnt,
  input logic [TW-1:0] cmp_a,
  input logic [2:0]    mode,
  input logic [2:0]    mode_q,
  input logic          gpio_val,
  input logic          flt_n,
  input logic          pin_o,
  input logic          irq_o,
  input logic          flt_o
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!pin_o && !irq_o && !flt_o));

  a_r2_gpio_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b000 && mode == 3'b000) |=> (pin_o == $past(gpio_val) && !irq_o));

  a_r4_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b001 && mode == 3'b001 && tmr_cnt == cmp_a) |=> pin_o);

  a_r9_plain_pwm_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b110 && mode == 3'b110) |=> !irq_o);

  a_r10_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b111 && !flt_n) |-> !pin_o);

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_o && mode == mode_q) |=> flt_o);
endmodule

bind ocmp_channel ocmp_channel_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .cmp_a(cmp_a),
  .mode(mode), .mode_q(mode_q), .gpio_val(gpio_val), .flt_n(flt_n),
  .pin_o(pin_o), .irq_o(irq_o), .flt_o(flt_o)
);

// File: tb/tb_ocmp_channel.sv
module tb_ocmp_channel;
  localparam int TW  = 16;
  localparam int PER = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] tmr_cnt = '0;
  logic          tmr_pm = 1'b0;
  logic [TW-1:0] cmp_a = '0;
  logic [TW-1:0] cmp_b = '0;
  logic [2:0]    mode = 3'b000;
  logic          gpio_val = 1'b0;
  logic          flt_n = 1'b1;
  logic          pin_o, irq_o, flt_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  typedef struct {
    logic  p;
    logic  i;
    logic  f;
    string tag;
  } exp_t;
  exp_t sb[$];

  ocmp_channel #(.TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .tmr_pm(tmr_pm),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .mode(mode), .gpio_val(gpio_val),
    .flt_n(flt_n), .pin_o(pin_o), .irq_o(irq_o), .flt_o(flt_o)
  );

  always #(PER/2) clk = ~clk;

  task automatic compare(input logic p, input logic i, input logic f, input string tag);
    checks++;
    if (pin_o !== p || irq_o !== i || flt_o !== f) begin
      fails++;
      $display("FAIL %s: pin/irq/flt actual=%b%b%b expected=%b%b%b",
               tag, pin_o, irq_o, flt_o, p, i, f);
    end
  endtask

  task automatic tick(input logic p, input logic i, input logic f, input string tag);
    exp_t e;
    e.p = p; e.i = i; e.f = f; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #(PER/4);
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      compare(e.p, e.i, e.f, e.tag);
    end
  end

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PER * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(1'b0, 1'b0, 1'b0, "R1 reset");
    rst_n = 1'b1;

    gpio_val = 1'b1;              tick(1, 0, 0, "R2 follow high");
    gpio_val = 1'b0;              tick(0, 0, 0, "R2 follow low");

    cmp_a = 5; mode = 3'b001;     tick(0, 0, 0, "R3 entry 001");
    tmr_cnt = 4;                  tick(0, 0, 0, "R4 no match");
    tmr_cnt = 5;                  tick(1, 1, 0, "R4 rise irq");
    tmr_cnt = 6;                  tick(1, 0, 0, "R11 single pulse");

    mode = 3'b010; tmr_cnt = 0;   tick(1, 0, 0, "R3 entry 010");
    tmr_cnt = 5;                  tick(0, 1, 0, "R5 fall irq");
    tmr_cnt = 6;                  tick(0, 0, 0, "R5 hold");

    mode = 3'b000; gpio_val = 1'b1; tick(1, 0, 0, "R2 gpio high");
    mode = 3'b011; tmr_cnt = 0;   tick(1, 0, 0, "R3 toggle keeps level");
    gpio_val = 1'b0; tmr_cnt = 5; tick(0, 1, 0, "R6 toggle fall");
    tmr_cnt = 7;                  tick(0, 0, 0, "R6 hold");
    tmr_cnt = 5;                  tick(1, 1, 0, "R6 toggle rise");

    cmp_a = 3; cmp_b = 6; mode = 3'b100; tmr_cnt = 0; tick(0, 0, 0, "R3 entry 100");
    tmr_cnt = 3;                  tick(1, 0, 0, "R7 rise no irq");
    tmr_cnt = 4;                  tick(1, 0, 0, "R7 high");
    tmr_cnt = 6;                  tick(0, 1, 0, "R7 fall irq");
    tmr_cnt = 3;                  tick(0, 0, 0, "R7 stays low");
    tmr_cnt = 6;                  tick(0, 0, 0, "R7 stays low");
    mode = 3'b000;                tick(0, 0, 0, "R2 leave");
    mode = 3'b100; tmr_cnt = 0;   tick(0, 0, 0, "R3 rearm");
    tmr_cnt = 3;                  tick(1, 0, 0, "R3 rearmed rise");
    tmr_cnt = 6;                  tick(0, 1, 0, "R7 fall again");

    mode = 3'b101; tmr_cnt = 0;   tick(0, 0, 0, "R3 entry 101");
    for (int k = 0; k < 2; k++) begin
      tmr_cnt = 3;                tick(1, 0, 0, "R8 rise");
      tmr_cnt = 6;                tick(0, 1, 0, "R8 fall irq");
    end

    cmp_a = 0; cmp_b = 4; mode = 3'b110; tmr_cnt = 0; tick(0, 0, 0, "R3 pwm zero primary");
    tmr_pm = 1;                   tick(1, 0, 0, "R9 period rise");
    tmr_pm = 0; tmr_cnt = 2;      tick(1, 0, 0, "R9 high");
    cmp_b = 1; tmr_cnt = 3;       tick(1, 0, 0, "R9 mid-period change");
    tmr_cnt = 4;                  tick(0, 0, 0, "R9 fall at old duty");
    tmr_cnt = 9;                  tick(0, 0, 0, "R9 low");
    tmr_pm = 1; tmr_cnt = 0;      tick(1, 0, 0, "R9 period rise");
    tmr_pm = 0; tmr_cnt = 1;      tick(0, 0, 0, "R9 new duty");
    cmp_b = 0; tmr_pm = 1; tmr_cnt = 0; tick(0, 0, 0, "R9 zero duty");
    tmr_pm = 0;
    mode = 3'b000;                tick(0, 0, 0, "R2 leave");
    cmp_a = 7; mode = 3'b110;     tick(1, 0, 0, "R3 pwm nonzero primary");
    tmr_cnt = 7;                  tick(0, 0, 0, "R9 first duty from primary");

    cmp_b = 5; mode = 3'b111; tmr_cnt = 0; tick(1, 0, 0, "R3 entry 111");
    tmr_pm = 1;                   tick(1, 0, 0, "R9 period in 111");
    tmr_pm = 0; tmr_cnt = 2;      tick(1, 0, 0, "R9 high in 111");
    flt_n = 1'b0;
    #1 compare(0, 0, 0, "R10 immediate force");
    tick(0, 1, 1, "R10 fault flag irq");
    flt_n = 1'b1; tmr_cnt = 3;    tick(0, 0, 1, "R10 stays off");
    tmr_pm = 1; tmr_cnt = 0;      tick(0, 0, 1, "R10 off across period");
    tmr_pm = 0; mode = 3'b110;    tick(1, 0, 0, "R10 rewrite clears");
    mode = 3'b111;                tick(1, 0, 0, "R3 reenter 111");
    tmr_pm = 1; flt_n = 1'b0;     tick(0, 1, 1, "R10 fault with period strobe");
    tmr_pm = 0; flt_n = 1'b1;     tick(0, 0, 1, "R10 single irq");
    mode = 3'b110;                tick(1, 0, 0, "R10 rewrite clears");
    flt_n = 1'b0;                 tick(1, 0, 0, "R9 fault ignored in 110");
    tmr_pm = 1;                   tick(1, 0, 0, "R9 fault ignored in 110");
    tmr_pm = 0; flt_n = 1'b1;     tick(1, 0, 0, "R9 high");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule